// File: doc/BRIEF.md
# Packet Transfer Control and Status Registers

This block holds the software-visible control and status of a packet-based FIFO transfer engine. Software sets a master enable and two interrupt enables, one for packets that end in error and one for packets that finish cleanly. It also issues a restart, which gives the transfer state machine a single-cycle start pulse. The engine reports two kinds of event. An abnormal end happens only after a FIFO error, and a normal end happens at the close of a good packet. Each event sets a sticky flag whether or not its interrupt is enabled. Software clears a flag by writing 1 to it.

A single CPU interrupt line is raised while an enabled flag is set. Flags clear in three other ways: a reset-control bit held high, the master enable held low, or a restart. The status word also carries the engine's running count of bytes moved. That count returns to zero on a restart.

The register bus is a single-cycle write strobe with byte enables. Read data is registered one clock after the address is presented.

Top module: `pkt_csr`

## Requirements
- R1: After synchronous reset, the control word reads 0, status bits 31..24 read 0, and both `irq_o` and `restart_o` are 0.
- R2: The control word (address 1) keeps master enable at bit 0, normal-end interrupt enable at bit 8, error-end interrupt enable at bit 9 and reset-control at bit 24. All other bits read 0, and each bit is written only when the enable of its byte lane (`reg_be[bit/8]`) is 1.
- R3: The error-end flag (status bit 28, address 2) sets one clock after `fifo_err_i` is sampled high while master enable is 1 and reset-control is 0. This happens whatever the error-end interrupt enable holds.
- R4: The normal-end flag (status bit 24) sets one clock after `pkt_done_i` is sampled high under the same conditions, whatever the normal-end interrupt enable holds.
- R5: A status write with `reg_be[3]`=1 clears each flag whose bit is written as 1. Writing 0, or writing with `reg_be[3]`=0, leaves the flags unchanged.
- R6: When a flag's set event and a software clear of that flag arrive in the same cycle, the flag ends up set.
- R7: `irq_o` is registered and equals (error flag AND error enable) OR (normal flag AND normal enable), taken from the state one cycle earlier.
- R8: While master enable is 0, both flags are held at 0, events are ignored and `irq_o` goes to 0.
- R9: While reset-control is 1, both flags are held at 0.
- R10: A write to address 0 with `reg_be[3]`=1, data bit 24 = 1 and master enable = 1 produces `restart_o` high for exactly the next cycle. No pulse is produced if any of these conditions is missing.
- R11: The cycle after a restart pulse, both flags are 0 and the bytes-done field is 0.
- R12: Status bits 23..0 show `bytes_i` as registered one cycle earlier, except after a restart. Status bits 31..29 and 27..25 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word address: 0 packet size, 1 control, 2 status |
| reg_be | input | 4 | Byte-lane enables for writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| fifo_err_i | input | 1 | Packet ended abnormally because of a FIFO error |
| pkt_done_i | input | 1 | Packet ended normally |
| bytes_i | input | CNT_W | Running count of bytes moved by the engine |
| restart_o | output | 1 | One-cycle start pulse to the transfer state machine |
| irq_o | output | 1 | CPU interrupt |

## Verification
The hardest situation to reach from the ports is a cycle in which the engine raises an event and a software write-one clears the same flag. The bench drives `fifo_err_i` in the same clock as a status write that clears both flags. The error flag must survive, while the normal flag, which has no event that cycle, must clear. The bench also checks the restart path. It sets both flags and a non-zero byte count, issues a restart, and reads status twice: the first read must show flags and count at zero, and the second must show the count refilled from `bytes_i`.

// File: rtl/pkt_csr_pkg.sv
package pkt_csr_pkg;

  localparam int DATA_W   = 32;
  localparam int LANES    = DATA_W / 8;

  // word addresses
  localparam int A_SIZE   = 0;
  localparam int A_CTRL   = 1;
  localparam int A_STAT   = 2;

  // control word bit positions (lsb-0)
  localparam int ME_BIT   = 0;
  localparam int NIE_BIT  = 8;
  localparam int AIE_BIT  = 9;
  localparam int RC_BIT   = 24;

  // status word bit positions (lsb-0)
  localparam int NT_BIT   = 24;
  localparam int AT_BIT   = 28;
  localparam int CNT_MAXW = 24;

  // packet-size word: restart request bit
  localparam int GO_BIT   = 24;

  // flag indices
  localparam int F_AT     = 0;
  localparam int F_NT     = 1;
  localparam int NFLAG    = 2;

  typedef struct packed {
    logic rc;
    logic aie;
    logic nie;
    logic me;
  } ctrl_t;

endpackage

// File: rtl/pkt_csr_ctrl.sv
module pkt_csr_ctrl
  import pkt_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl_i,
  input  logic              wr_size_i,
  input  logic [LANES-1:0]  be_i,
  input  logic [DATA_W-1:0] wdata_i,
  output ctrl_t             ctrl_o,
  output logic              restart_o
);

  ctrl_t ctrl_q;
  logic  restart_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_ctrl_i) begin
      if (be_i[ME_BIT/8])  ctrl_q.me  <= wdata_i[ME_BIT];
      if (be_i[NIE_BIT/8]) ctrl_q.nie <= wdata_i[NIE_BIT];
      if (be_i[AIE_BIT/8]) ctrl_q.aie <= wdata_i[AIE_BIT];
      if (be_i[RC_BIT/8])  ctrl_q.rc  <= wdata_i[RC_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) restart_q <= 1'b0;
    else     restart_q <= wr_size_i && be_i[GO_BIT/8] && wdata_i[GO_BIT] && ctrl_q.me;
  end

  assign ctrl_o    = ctrl_q;
  assign restart_o = restart_q;

  // R10: a pulse is always caused by a packet-size write in the cycle before
  p_pulse_from_write_r10: assert property (@(posedge clk) disable iff (rst)
    restart_q |-> $past(wr_size_i));

endmodule

// File: rtl/pkt_csr_flag.sv
module pkt_csr_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic w1c_i,
  input  logic force_clr_i,
  output logic flag_o
);

  logic flag_q;

  // forced clears dominate; a hardware set beats a software clear
  always_ff @(posedge clk) begin
    if (rst)              flag_q <= 1'b0;
    else if (force_clr_i) flag_q <= 1'b0;
    else if (set_i)       flag_q <= 1'b1;
    else if (w1c_i)       flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  // R6: an unforced set always lands, even with a clear in the same cycle
  p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
    (set_i && !force_clr_i) |=> flag_q);

  // R5: without a set, a write-one clear empties the flag
  p_w1c_clears_r5: assert property (@(posedge clk) disable iff (rst)
    (w1c_i && !set_i) |=> !flag_q);

endmodule

// File: rtl/pkt_csr_count.sv
module pkt_csr_count #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             zero_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q;

  // no reset: the field has no defined value until the engine drives it
  always_ff @(posedge clk) begin
    if (zero_i) cnt_q <= '0;
    else        cnt_q <= cnt_i;
  end

  assign cnt_o = cnt_q;

  // R11: restart zeroes the count
  p_zero_on_restart_r11: assert property (@(posedge clk) disable iff (rst)
    zero_i |=> (cnt_q == '0));

  // R12: otherwise the count tracks the engine input one cycle later
  p_count_tracks_r12: assert property (@(posedge clk) disable iff (rst)
    !zero_i |=> (cnt_q == $past(cnt_i)));

endmodule

// File: rtl/pkt_csr.sv
module pkt_csr
  import pkt_csr_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [3:0]        reg_be,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              fifo_err_i,
  input  logic              pkt_done_i,
  input  logic [CNT_W-1:0]  bytes_i,
  output logic              restart_o,
  output logic              irq_o
);

  localparam logic [ADDR_W-1:0] AD_SIZE = ADDR_W'(A_SIZE);
  localparam logic [ADDR_W-1:0] AD_CTRL = ADDR_W'(A_CTRL);
  localparam logic [ADDR_W-1:0] AD_STAT = ADDR_W'(A_STAT);

  logic wr_size, wr_ctrl, wr_stat;
  assign wr_size = reg_wr && (reg_addr == AD_SIZE);
  assign wr_ctrl = reg_wr && (reg_addr == AD_CTRL);
  assign wr_stat = reg_wr && (reg_addr == AD_STAT);

  ctrl_t ctrl;
  logic  restart;

  pkt_csr_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wr_ctrl_i (wr_ctrl),
    .wr_size_i (wr_size),
    .be_i      (reg_be),
    .wdata_i   (reg_wdata),
    .ctrl_o    (ctrl),
    .restart_o (restart)
  );

  logic             force_clr;
  logic [NFLAG-1:0] set_ev;
  logic [NFLAG-1:0] flag;

  assign force_clr     = !ctrl.me || ctrl.rc || restart;
  assign set_ev[F_AT]  = fifo_err_i;
  assign set_ev[F_NT]  = pkt_done_i;

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    localparam int POS = (g == F_AT) ? AT_BIT : NT_BIT;
    logic w1c;
    assign w1c = wr_stat && reg_be[POS/8] && reg_wdata[POS];
    pkt_csr_flag u_flag (
      .clk         (clk),
      .rst         (rst),
      .set_i       (set_ev[g]),
      .w1c_i       (w1c),
      .force_clr_i (force_clr),
      .flag_o      (flag[g])
    );
  end

  logic [CNT_W-1:0] cnt;

  pkt_csr_count #(.CNT_W(CNT_W)) u_count (
    .clk    (clk),
    .rst    (rst),
    .zero_i (restart),
    .cnt_i  (bytes_i),
    .cnt_o  (cnt)
  );

  logic irq_q;
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= (flag[F_AT] && ctrl.aie) || (flag[F_NT] && ctrl.nie);
  end

  logic [31:0] ctrl_word, stat_word;
  always_comb begin
    ctrl_word          = '0;
    ctrl_word[ME_BIT]  = ctrl.me;
    ctrl_word[NIE_BIT] = ctrl.nie;
    ctrl_word[AIE_BIT] = ctrl.aie;
    ctrl_word[RC_BIT]  = ctrl.rc;
    stat_word          = '0;
    stat_word[CNT_W-1:0] = cnt;
    stat_word[AT_BIT]  = flag[F_AT];
    stat_word[NT_BIT]  = flag[F_NT];
  end

  logic [31:0] rdata_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      case (reg_addr)
        AD_CTRL: rdata_q <= ctrl_word;
        AD_STAT: rdata_q <= stat_word;
        default: rdata_q <= '0;
      endcase
    end
  end

  assign reg_rdata = rdata_q;
  assign restart_o = restart;
  assign irq_o     = irq_q;

  // R8: master enable low empties both flags
  p_me_low_clears_r8: assert property (@(posedge clk) disable iff (rst)
    !ctrl.me |=> (flag == '0));

  // R9: reset-control high empties both flags
  p_rc_clears_r9: assert property (@(posedge clk) disable iff (rst)
    ctrl.rc |=> (flag == '0));

  // R11: restart pulse empties both flags
  p_restart_clears_r11: assert property (@(posedge clk) disable iff (rst)
    restart |=> (flag == '0));

  // R7: no interrupt without a set flag in the cycle before
  p_irq_needs_flag_r7: assert property (@(posedge clk) disable iff (rst)
    (flag == '0) |=> !irq_q);

endmodule

// File: tb/tb_pkt_csr.sv
module tb_pkt_csr;

  localparam int CLK_P  = 10;
  localparam int ADDR_W = 2;
  localparam int CNT_W  = 24;

  logic              clk = 1'b0;
  logic              rst;
  logic              reg_wr;
  logic [ADDR_W-1:0] reg_addr;
  logic [3:0]        reg_be;
  logic [31:0]       reg_wdata;
  logic [31:0]       reg_rdata;
  logic              fifo_err_i;
  logic              pkt_done_i;
  logic [CNT_W-1:0]  bytes_i;
  logic              restart_o;
  logic              irq_o;

  int tests = 0;
  int fails = 0;

  pkt_csr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .fifo_err_i(fifo_err_i), .pkt_done_i(pkt_done_i), .bytes_i(bytes_i),
    .restart_o(restart_o), .irq_o(irq_o)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d, input logic [3:0] be);
    reg_wr = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = d; reg_be = be;
    tick();
    reg_wr = 1'b0; reg_wdata = '0; reg_be = '0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    reg_addr = ADDR_W'(a);
    tick();
    d = reg_rdata;
  endtask

  task automatic evt(input logic ab, input logic nt);
    fifo_err_i = ab; pkt_done_i = nt;
    tick();
    fifo_err_i = 1'b0; pkt_done_i = 1'b0;
  endtask

  function automatic logic [31:0] cw(input logic me, input logic nie,
                                     input logic aie, input logic rc);
    return (32'(me) << 0) | (32'(nie) << 8) | (32'(aie) << 9) | (32'(rc) << 24);
  endfunction

  localparam logic [31:0] BOTH = 32'h1100_0000;

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst = 1'b1; reg_wr = 1'b0; reg_addr = '0; reg_be = '0; reg_wdata = '0;
    fifo_err_i = 1'b0; pkt_done_i = 1'b0; bytes_i = '0;
    repeat (3) tick();
    rst = 1'b0;

    // R1 reset state
    rd(1, d); chk("R1 ctrl", d, 32'h0);
    rd(2, d); chk("R1 status flags", d & 32'hFF00_0000, 32'h0);
    chk("R1 irq", 32'(irq_o), 32'h0);
    chk("R1 restart", 32'(restart_o), 32'h0);

    // R2 control fields, reserved bits, byte lanes
    for (int i = 0; i < 16; i++) begin
      logic [31:0] e;
      e = cw(i[0], i[1], i[2], i[3]);
      wr(1, e | 32'hFEFF_FCFE, 4'hF);
      rd(1, d); chk("R2 ctrl sweep", d, e);
    end
    wr(1, 32'h0, 4'hF);
    wr(1, 32'hFFFF_FFFF, 4'b0001); rd(1, d); chk("R2 lane0 only", d, 32'h1);
    wr(1, 32'hFFFF_FFFF, 4'b0010); rd(1, d); chk("R2 lane1 only", d, 32'h301);
    wr(1, 32'h0, 4'b0100);         rd(1, d); chk("R2 lane2 no bits", d, 32'h301);

    // R3 R4 R7 sweep over enables and events
    for (int en = 0; en < 4; en++) begin
      for (int ev = 0; ev < 4; ev++) begin
        logic nie, aie, ab, nt;
        nie = en[0]; aie = en[1]; ab = ev[1]; nt = ev[0];
        wr(1, cw(1'b1, nie, aie, 1'b0), 4'hF);
        wr(2, BOTH, 4'b1000);
        tick();
        evt(ab, nt);
        rd(2, d);
        chk("R3 error flag", 32'(d[28]), 32'(ab));
        chk("R4 normal flag", 32'(d[24]), 32'(nt));
        chk("R7 irq", 32'(irq_o), 32'((ab & aie) | (nt & nie)));
      end
    end

    // R5 write-one-to-clear
    wr(1, cw(1, 1, 1, 0), 4'hF);
    evt(1, 1);
    wr(2, 32'h0, 4'hF);         rd(2, d); chk("R5 write zero", d & BOTH, BOTH);
    wr(2, BOTH, 4'b0111);       rd(2, d); chk("R5 lane3 off", d & BOTH, BOTH);
    wr(2, 32'h1000_0000, 4'b1000); rd(2, d); chk("R5 clear error", d & BOTH, 32'h0100_0000);
    wr(2, 32'h0100_0000, 4'b1000); rd(2, d); chk("R5 clear normal", d & BOTH, 32'h0);

    // R6 set beats clear in the same cycle
    evt(1, 1);
    reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = BOTH; reg_be = 4'b1000; fifo_err_i = 1'b1;
    tick();
    reg_wr = 1'b0; reg_wdata = '0; reg_be = '0; fifo_err_i = 1'b0;
    rd(2, d); chk("R6 set wins", d & BOTH, 32'h1000_0000);

    // R8 master enable low
    evt(1, 1);
    wr(1, cw(0, 1, 1, 0), 4'hF);
    tick();
    rd(2, d); chk("R8 flags cleared", d & BOTH, 32'h0);
    chk("R8 irq low", 32'(irq_o), 32'h0);
    evt(1, 1);
    rd(2, d); chk("R8 events ignored", d & BOTH, 32'h0);
    chk("R8 irq stays low", 32'(irq_o), 32'h0);

    // R9 reset-control
    wr(1, cw(1, 1, 1, 1), 4'hF);
    evt(1, 1);
    rd(2, d); chk("R9 flags held", d & BOTH, 32'h0);
    chk("R9 irq low", 32'(irq_o), 32'h0);
    wr(1, cw(1, 1, 1, 0), 4'hF);

    // R10 R11 restart
    bytes_i = 24'hABCDE;
    evt(1, 1);
    wr(0, 32'h0100_0000, 4'b1000);
    chk("R10 pulse high", 32'(restart_o), 32'h1);
    tick();
    chk("R10 pulse one cycle", 32'(restart_o), 32'h0);
    rd(2, d);
    chk("R11 flags zero", d & BOTH, 32'h0);
    chk("R11 count zero", d & 32'h00FF_FFFF, 32'h0);
    rd(2, d); chk("R11 count refills", d & 32'h00FF_FFFF, 32'h000A_BCDE);
    wr(0, 32'h0100_0000, 4'b0111); chk("R10 lane3 off", 32'(restart_o), 32'h0);
    wr(0, 32'h0200_0000, 4'b1000); chk("R10 bit clear", 32'(restart_o), 32'h0);
    wr(1, cw(0, 0, 0, 0), 4'hF);
    wr(0, 32'h0100_0000, 4'b1000); chk("R10 master off", 32'(restart_o), 32'h0);
    wr(1, cw(1, 0, 0, 0), 4'hF);

    // R12 count tracking and reserved bits
    for (int i = 0; i < 16; i++) begin
      logic [CNT_W-1:0] v;
      v = CNT_W'(i * 32'h13579) ^ 24'hF0F0F;
      bytes_i = v;
      tick();
      rd(2, d);
      chk("R12 count", d & 32'h00FF_FFFF, 32'(v));
      chk("R12 reserved", d & 32'hEE00_0000, 32'h0);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule